// File: doc/BRIEF.md
# Keying Sample Recorder

This block records the up/down level of a Morse key into a 4096-location, one-bit memory and plays it back later. It shares the keyer's timebase. A sample-tick enable marks each keyer clock period. On every tick the block either stores one sample of the key level or reads one back, and then moves to the next location. A location therefore holds exactly one keyer period of key state, and playback at the same tick rate reproduces the message with its original timing.

A rewind control returns the address to location zero before a recording or a playback starts. The erase control sweeps the whole memory with key-up. It advances one location on every system clock rather than on every tick, so a full sweep takes only 4096 clocks. A bypass select sends the live key straight to the output and leaves both the memory and the address untouched.

Top module: `keying_recorder`

## Requirements
- R1: A cycle with `rst` high leaves `addr` at 0 and `key_out` at 0 on the following cycle.
- R2: In record mode (`rec_mode`=1), with `tick` high and `erase`, `rewind` and `bypass` low, the level of `key_in` is stored at the current address and `addr` increments by one at the same clock edge.
- R3: With `tick` low and `erase` and `rewind` low, `addr` and the memory contents stay unchanged.
- R4: In play mode (`rec_mode`=0), each tick increments `addr` and reads the location that was current at that tick. The bit read appears on `key_out` two clock edges after the tick edge and holds until the next read result arrives.
- R5: The address wraps from 4095 to 0 and nothing else happens at the wrap.
- R6: `rewind` high sets `addr` to 0 at the next edge. It overrides erase and tick, and it forces `key_out` to 0.
- R7: While `erase` is high and `rewind` is low, `addr` increments on every clock whatever `tick` and `rec_mode` are. Each location swept is written with 0 (key-up), and `key_out` is 0.
- R8: While `bypass` is high and `erase` and `rewind` are low, `key_out` equals `key_in` delayed by one clock. `addr` holds and no location is written, even when `tick` and `rec_mode` are high.
- R9: In record mode, `key_out` follows `key_in` with one clock of delay, so the operator can monitor what is being stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample enable, one pulse per keyer clock period |
| key_in | input | 1 | Live key level (1 = key down) |
| rec_mode | input | 1 | 1 = record, 0 = play |
| rewind | input | 1 | Return address to location zero |
| erase | input | 1 | Fast sweep writing key-up to every location |
| bypass | input | 1 | Pass key_in to key_out, memory untouched |
| key_out | output | 1 | Registered key level |
| addr | output | ADDR_W (12) | Current memory address |

## Verification
`addr` moves at the clock edge that samples a tick, an erase or a rewind. `key_out` reflects a live or forced value one edge after its cause, while a played-back bit needs two edges: one for the memory read and one for the output register. The bench drives every input on the falling edge and samples on the next falling edge. In playback it compares `key_out` with the sample of the address two edges back, so the first comparison falls on the second edge of a stream. Full 4096-location passes of recording, playback and erase exercise the wrap and the state after erase. Short windows in bypass and with tick low are each followed by a playback that shows which locations stayed unchanged.

// File: rtl/keyrec_pkg.sv
package keyrec_pkg;
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_CLEAR   = 2'd1,
    OP_ADVANCE = 2'd2
  } addr_op_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_LIVE = 2'd1,
    SRC_MEM  = 2'd2
  } out_src_e;
endpackage

// File: rtl/keyrec_ctrl.sv
module keyrec_ctrl
  import keyrec_pkg::*;
(
  input  logic     tick,
  input  logic     key_in,
  input  logic     rec_mode,
  input  logic     rewind,
  input  logic     erase,
  input  logic     bypass,
  output addr_op_e op,
  output logic     we,
  output logic     wbit,
  output logic     rd_en,
  output out_src_e src
);
  always_comb begin
    op    = OP_HOLD;
    we    = 1'b0;
    wbit  = 1'b0;
    rd_en = 1'b0;
    src   = SRC_MEM;
    if (rewind) begin
      op  = OP_CLEAR;
      src = SRC_ZERO;
    end else if (erase) begin
      op  = OP_ADVANCE;
      we  = 1'b1;
      src = SRC_ZERO;
    end else if (bypass) begin
      src = SRC_LIVE;
    end else if (rec_mode) begin
      src  = SRC_LIVE;
      we   = tick;
      wbit = key_in;
      if (tick) op = OP_ADVANCE;
    end else begin
      rd_en = tick;
      if (tick) op = OP_ADVANCE;
    end
  end
endmodule

// File: rtl/keyrec_addr_ctr.sv
module keyrec_addr_ctr
  import keyrec_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  addr_op_e          op,
  input  logic              rewind,
  input  logic              erase,
  input  logic              tick,
  input  logic              bypass,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else begin
      case (op)
        OP_CLEAR:   addr <= '0;
        OP_ADVANCE: addr <= (addr == LAST) ? '0 : addr + 1'b1;
        default:    addr <= addr;
      endcase
    end
  end

  AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (rst)
    rewind |=> addr == '0); // R6
  AST_ERASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (erase && !rewind) |=> addr == ADDR_W'($past(addr) + 1)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rewind && !erase && (!tick || bypass)) |=> $stable(addr)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == LAST && !rewind && (erase || (tick && !bypass))) |=> addr == '0); // R5
endmodule

// File: rtl/keyrec_bitmem.sv
module keyrec_bitmem #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              wbit,
  input  logic              rd_en,
  output logic              rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wbit;
    if (rd_en) rd_q <= mem[addr];
  end

  AST_NO_WRITE_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (bypass && !erase) |-> !we); // R8
  AST_ERASE_KEYUP: assert property (@(posedge clk) disable iff (rst)
    (erase && we) |-> !wbit); // R7
  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (rst)
    !(we && rd_en)); // R4
endmodule

// File: rtl/keyrec_outreg.sv
module keyrec_outreg
  import keyrec_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  out_src_e src,
  input  logic     key_in,
  input  logic     rd_en,
  input  logic     rd_q,
  input  logic     bypass,
  input  logic     erase,
  input  logic     rewind,
  output logic     key_out
);
  logic rd_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      key_out <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      case (src)
        SRC_ZERO: key_out <= 1'b0;
        SRC_LIVE: key_out <= key_in;
        default:  if (rd_vld) key_out <= rd_q;
      endcase
    end
  end

  AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (bypass && !erase && !rewind) |=> key_out == $past(key_in)); // R8
  AST_SWEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (erase || rewind) |=> !key_out); // R6
endmodule

// File: rtl/keying_recorder.sv
module keying_recorder
  import keyrec_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              key_in,
  input  logic              rec_mode,
  input  logic              rewind,
  input  logic              erase,
  input  logic              bypass,
  output logic              key_out,
  output logic [ADDR_W-1:0] addr
);
  addr_op_e op;
  out_src_e src;
  logic     we, wbit, rd_en, rd_q;

  keyrec_ctrl u_ctrl (
    .tick(tick), .key_in(key_in), .rec_mode(rec_mode), .rewind(rewind),
    .erase(erase), .bypass(bypass), .op(op), .we(we), .wbit(wbit),
    .rd_en(rd_en), .src(src)
  );

  keyrec_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .op(op), .rewind(rewind), .erase(erase),
    .tick(tick), .bypass(bypass), .addr(addr)
  );

  keyrec_bitmem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst(rst), .bypass(bypass), .erase(erase), .addr(addr),
    .we(we), .wbit(wbit), .rd_en(rd_en), .rd_q(rd_q)
  );

  keyrec_outreg u_out (
    .clk(clk), .rst(rst), .src(src), .key_in(key_in), .rd_en(rd_en),
    .rd_q(rd_q), .bypass(bypass), .erase(erase), .rewind(rewind),
    .key_out(key_out)
  );
endmodule

// File: tb/test_keying_recorder.sv
module test_keying_recorder;
  localparam int AW = 12;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst, tick, key_in, rec_mode, rewind, erase, bypass;
  logic key_out;
  logic [AW-1:0] addr;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keying_recorder #(.ADDR_W(AW)) i_keying_recorder (
    .clk(clk), .rst(rst), .tick(tick), .key_in(key_in), .rec_mode(rec_mode),
    .rewind(rewind), .erase(erase), .bypass(bypass), .key_out(key_out),
    .addr(addr)
  );

  function automatic bit pat(int i);
    return ((i * 13 + (i >> 4)) % 3) == 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    tick = 0; key_in = 0; rewind = 0; erase = 0; bypass = 0;
  endtask

  task automatic do_rewind();
    idle(); rewind = 1; cyc(); rewind = 0;
  endtask

  initial begin
    rst = 1; rec_mode = 0; idle();
    repeat (3) cyc();
    rst = 0;
    chk(addr == 0, "R1 addr", addr, 0);
    chk(key_out == 0, "R1 key_out", key_out, 0);

    // record a full pass with wrap (R2, R5, R9)
    do_rewind();
    chk(addr == 0, "R6 rewind", addr, 0);
    rec_mode = 1;
    for (int i = 0; i < N; i++) begin
      tick = 1; key_in = pat(i); cyc();
      chk(addr == AW'((i + 1) % N), (i == N - 1) ? "R5 wrap" : "R2 step", addr, (i + 1) % N);
      chk(key_out == pat(i), "R9 monitor", key_out, pat(i));
    end

    // tick low: address holds (R3)
    idle(); rec_mode = 1; key_in = 1;
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk(addr == 0, "R3 hold", addr, 0);
    end

    // bypass at address 0 with complement data (R8)
    do_rewind();
    bypass = 1; tick = 1; rec_mode = 1;
    for (int i = 0; i < 6; i++) begin
      key_in = ~pat(i); cyc();
      chk(addr == 0, "R8 addr hold", addr, 0);
      chk(key_out == !pat(i), "R8 pass", key_out, !pat(i));
    end

    // full playback with wrap (R4, R5, R8 memory untouched)
    do_rewind();
    chk(key_out == 0, "R6 key_out", key_out, 0);
    rec_mode = 0;
    for (int i = 0; i <= N; i++) begin
      tick = 1; cyc();
      chk(addr == AW'((i + 1) % N), "R4 addr", addr, (i + 1) % N);
      if (i >= 1) chk(key_out == pat((i - 1) % N), (i <= 6) ? "R8 mem kept" : "R4 play",
                      key_out, pat((i - 1) % N));
    end

    // playback hold between ticks (R4)
    do_rewind(); rec_mode = 0;
    tick = 1; cyc(); tick = 0; cyc();
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk(key_out == pat(0), "R4 hold", key_out, pat(0));
      chk(addr == 1, "R3 play hold", addr, 1);
    end

    // erase with rewind priority (R6)
    do_rewind();
    erase = 1; rec_mode = 1; key_in = 1;
    cyc(); cyc();
    rewind = 1; cyc();
    chk(addr == 0, "R6 over erase", addr, 0);
    rewind = 0;

    // full erase with tick toggling and key_in high (R7)
    for (int i = 0; i < N; i++) begin
      tick = i[0]; cyc();
      chk(addr == AW'((i + 1) % N), "R7 step", addr, (i + 1) % N);
      chk(key_out == 0, "R7 quiet", key_out, 0);
    end

    // play back erased memory (R7)
    do_rewind(); rec_mode = 0;
    for (int i = 0; i <= N; i++) begin
      tick = 1; cyc();
      if (i >= 1) chk(key_out == 0, "R7 erased", key_out, 0);
    end
    idle();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule